// File: doc/BRIEF.md
# Register-List Stack Push Sequencer

This block carries out a multi-register push onto a descending stack. A single start pulse hands it a 32-bit selection mask, the current stack pointer and a snapshot of the processor status word. The block then scans the mask. For each selected item it reads the value, lowers the stack pointer by four and issues one 32-bit memory write at the new pointer. Each write goes through a request/acknowledge port.

The top mask bit selects the status word, which is always pushed first. The remaining 31 bits select general registers, which are visited from the highest index to the lowest. Register values are read through an asynchronous read port: the block drives the index and samples the data in the same cycle. When the last write has been acknowledged, the block presents the lowered stack pointer together with a one-cycle completion pulse. Instruction decode, memory protection and the register file itself sit outside the block.

Top module: `regpush_seq`

## Requirements
- R1: When mask bit 31 is set, the first write carries the latched status word, ahead of every general register.
- R2: General registers whose mask bits (bits 30..0 select registers 30..0) are set are written in descending index order. Cleared bits produce no write. During each register write the value is read from the register named on `rf_idx`.
- R3: Each write goes to the stack pointer minus 4, where the stack pointer is the value after the previous write (or `sp_in` for the first write). Addresses wrap modulo 2^32. The final `sp_out` equals `sp_in` minus 4 times the number of set mask bits.
- R4: While `wr_valid` is high and `wr_ack` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged. The block moves to the next item only after an acknowledge.
- R5: A start with an all-zero mask gives `done` in the cycle after the start, with `sp_out` equal to `sp_in`, no write request and `busy` never raised.
- R6: For a non-zero mask, `busy` is high from the cycle after the start until the cycle after the last acknowledge. At that point `done` is high for exactly one cycle, together with the final `sp_out`.
- R7: A start pulse while `busy` is high is ignored, and the running push list is not altered.
- R8: Synchronous reset clears `busy`, `done`, `wr_valid` and `sp_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a push list (ignored while busy) |
| sel_mask | input | 32 | Bit 31 selects the status word; bits 30..0 select registers |
| sp_in | input | 32 | Stack pointer at start |
| psw_in | input | 32 | Status word snapshot at start |
| rf_idx | output | 5 | Register file read index |
| rf_rdata | input | 32 | Register file read data (asynchronous) |
| wr_valid | output | 1 | Write request |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write acknowledge |
| busy | output | 1 | Push list in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 32 | Final stack pointer, valid with done |

## Verification
The push is tried with five masks. A status-word-only mask separates the status path from the register path. A register-0-only mask and a register-30-only mask test the two ends of the scan. A sparse mixed mask with a stack pointer near zero exposes ordering and address wrap. A full mask checks all 32 writes and the total pointer drop. The mask runs use different acknowledge delays, which show whether the request is held until it is accepted. Directed cases then cover reset, the empty mask and a start issued during a running list.

// File: rtl/regpush_pkg.sv
package regpush_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_WAIT = 2'd2
  } push_st_e;
endpackage

// File: rtl/regpush_pick.sv
// Priority picker: reports the highest set bit of the pending vector.
module regpush_pick #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  // R2: the chosen index must point at a pending bit
  always_comb begin
    if (any) a_r2_pick_set: assert (vec[idx]);
  end
endmodule

// File: rtl/regpush_port.sv
// Write request holder: loads a request and keeps it until acknowledged.
module regpush_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          ack,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= ld_addr;
      data  <= ld_data;
    end else if (valid && ack) begin
      valid <= 1'b0;
    end
  end

  a_r4_hold_req: assert property (@(posedge clk) disable iff (rst)
    (valid && !ack) |=> (valid && $stable(addr) && $stable(data)));
endmodule

// File: rtl/regpush_seq.sv
module regpush_seq
  import regpush_pkg::*;
#(
  parameter int DW = 32,
  parameter int MW = 32,
  localparam int NREG = MW - 1,
  localparam int PIW  = $clog2(MW),
  localparam int RIW  = $clog2(NREG),
  localparam int STEP = DW / 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [MW-1:0]  sel_mask,
  input  logic [DW-1:0]  sp_in,
  input  logic [DW-1:0]  psw_in,
  output logic [RIW-1:0] rf_idx,
  input  logic [DW-1:0]  rf_rdata,
  output logic           wr_valid,
  output logic [DW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data,
  input  logic           wr_ack,
  output logic           busy,
  output logic           done,
  output logic [DW-1:0]  sp_out
);
  push_st_e      st;
  logic [MW-1:0] pending;
  logic [DW-1:0] sp_r;
  logic [DW-1:0] psw_r;
  logic          any;
  logic [PIW-1:0] top;
  logic          issue;
  logic [DW-1:0] push_val;
  logic [DW-1:0] sp_next;

  regpush_pick #(.W(MW), .IW(PIW)) u_pick (
    .vec (pending),
    .any (any),
    .idx (top)
  );

  assign rf_idx   = RIW'(top);
  assign issue    = (st == ST_LOAD);
  assign push_val = (top == PIW'(MW - 1)) ? psw_r : rf_rdata;
  assign sp_next  = sp_r - DW'(STEP);

  regpush_port #(.AW(DW), .DW(DW)) u_port (
    .clk     (clk),
    .rst     (rst),
    .load    (issue),
    .ld_addr (sp_next),
    .ld_data (push_val),
    .ack     (wr_ack),
    .valid   (wr_valid),
    .addr    (wr_addr),
    .data    (wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      pending <= '0;
      sp_r    <= '0;
      psw_r   <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      sp_out  <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            pending <= sel_mask;
            sp_r    <= sp_in;
            psw_r   <= psw_in;
            if (sel_mask == '0) begin
              done   <= 1'b1;
              sp_out <= sp_in;
            end else begin
              busy <= 1'b1;
              st   <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          pending[top] <= 1'b0;
          sp_r         <= sp_next;
          st           <= ST_WAIT;
        end
        ST_WAIT: begin
          if (wr_valid && wr_ack) begin
            if (!any) begin
              busy   <= 1'b0;
              done   <= 1'b1;
              sp_out <= sp_r;
              st     <= ST_IDLE;
            end else begin
              st <= ST_LOAD;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r5_empty_done: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && sel_mask == '0) |=> (done && !busy && !wr_valid));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_valid_busy: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> busy);

  a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !(wr_valid && wr_ack)) |=> busy);
endmodule

// File: tb/regpush_seq_bench.sv
module regpush_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] sel_mask = '0;
  logic [31:0] sp_in = '0;
  logic [31:0] psw_in = '0;
  logic [4:0]  rf_idx;
  logic [31:0] rf_rdata;
  logic        wr_valid;
  logic [31:0] wr_addr;
  logic [31:0] wr_data;
  logic        wr_ack = 1'b0;
  logic        busy;
  logic        done;
  logic [31:0] sp_out;

  int total = 0;
  int bad = 0;
  int stall_cfg = 0;
  int wcount = 0;
  logic [31:0] got_a [40];
  logic [31:0] got_d [40];

  always #2.5 clk = ~clk;

  // Register file model: value is a function of the index
  assign rf_rdata = 32'hD000_0000 | ({27'd0, rf_idx} << 8) | {27'd0, rf_idx};

  regpush_seq u_regpush_seq (
    .clk(clk), .rst(rst), .start(start), .sel_mask(sel_mask),
    .sp_in(sp_in), .psw_in(psw_in), .rf_idx(rf_idx), .rf_rdata(rf_rdata),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack), .busy(busy), .done(done), .sp_out(sp_out)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory responder: acknowledges after stall_cfg cycles, records writes
  initial begin
    int cnt;
    logic seen;
    logic [31:0] fa, fd;
    cnt = 0;
    seen = 1'b0;
    fa = '0;
    fd = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        wr_ack = 1'b0; cnt = 0; seen = 1'b0;
      end else if (wr_ack) begin
        wr_ack = 1'b0;
      end else if (wr_valid) begin
        if (!seen) begin fa = wr_addr; fd = wr_data; seen = 1'b1; end
        if (cnt < stall_cfg) cnt++;
        else begin
          chk(wr_addr == fa, "R4 addr held", wr_addr, fa);
          chk(wr_data == fd, "R4 data held", wr_data, fd);
          if (wcount < 40) begin
            got_a[wcount] = wr_addr;
            got_d[wcount] = wr_data;
          end
          wcount++;
          wr_ack = 1'b1;
          cnt = 0;
          seen = 1'b0;
        end
      end
    end
  end

  task automatic run(input logic [31:0] m, input logic [31:0] sp,
                     input logic [31:0] psw, input int stall, input logic poke);
    logic [31:0] ea [40];
    logic [31:0] ed [40];
    int n;
    logic [31:0] s;
    int guard;
    n = 0;
    s = sp;
    if (m[31]) begin s = s - 4; ea[n] = s; ed[n] = psw; n++; end
    for (int i = 30; i >= 0; i--) begin
      if (m[i]) begin
        s = s - 4; ea[n] = s;
        ed[n] = 32'hD000_0000 | (32'(i) << 8) | 32'(i);
        n++;
      end
    end
    wcount = 0;
    stall_cfg = stall;
    @(negedge clk);
    start = 1'b1; sel_mask = m; sp_in = sp; psw_in = psw;
    @(negedge clk);
    start = 1'b0;
    if (m == 0) begin
      chk(done == 1'b1, "R5 done next cycle", 32'(done), 32'd1);
      chk(busy == 1'b0, "R5 busy low", 32'(busy), 32'd0);
      chk(wr_valid == 1'b0, "R5 no request", 32'(wr_valid), 32'd0);
    end else begin
      chk(busy == 1'b1, "R6 busy after start", 32'(busy), 32'd1);
      if (poke) begin
        start = 1'b1; sel_mask = 32'hFFFF_FFFF; sp_in = 32'h0; psw_in = 32'h1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    guard = 0;
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    chk(sp_out == s, "R3 final sp", sp_out, s);
    chk(wcount == n, "R2 write count", 32'(wcount), 32'(n));
    for (int k = 0; k < n && k < wcount; k++) begin
      chk(got_a[k] == ea[k], "R3 address", got_a[k], ea[k]);
      chk(got_d[k] == ed[k], (k == 0 && m[31]) ? "R1 status first" : "R2 data order",
          got_d[k], ed[k]);
    end
    if (poke) chk(wcount == n, "R7 start ignored", 32'(wcount), 32'(n));
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", 32'(done), 32'd0);
    chk(busy == 1'b0, "R6 busy cleared", 32'(busy), 32'd0);
    if (m == 0) chk(wcount == 0, "R5 no writes", 32'(wcount), 32'd0);
  endtask

  // {mask, sp, psw, stall}
  localparam logic [127:0] VEC [5] = '{
    {32'h8000_0000, 32'h0000_1000, 32'hCAFE_0001, 32'd0},
    {32'h0000_0001, 32'h0000_2000, 32'h0000_0000, 32'd1},
    {32'h4000_0000, 32'h0000_3000, 32'h0000_0000, 32'd0},
    {32'hC000_0005, 32'h0000_0008, 32'h1234_5678, 32'd2},
    {32'hFFFF_FFFF, 32'h0001_0000, 32'h55AA_55AA, 32'd0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R8 reset busy", 32'(busy), 32'd0);
    chk(done == 1'b0, "R8 reset done", 32'(done), 32'd0);
    chk(wr_valid == 1'b0, "R8 reset valid", 32'(wr_valid), 32'd0);
    chk(sp_out == 32'd0, "R8 reset sp_out", sp_out, 32'd0);
    rst = 1'b0;
    for (int v = 0; v < 5; v++) begin
      run(VEC[v][127:96], VEC[v][95:64], VEC[v][63:32], int'(VEC[v][31:0]), 1'b0);
    end
    run(32'h0, 32'h0000_4444, 32'h0, 0, 1'b0);
    run(32'hC000_0005, 32'h0000_0100, 32'hBEEF_0000, 3, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule